// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that lets a host read and write a bank of thirty-two byte-wide storage registers. The host pulls the active-low select line low, clocks in a command byte, then moves one data byte. On a write the host sends the data byte. On a read the block returns the contents of the addressed register on its serial output. The registers hold only what was written to them. They have no other meaning inside this block.

The port runs entirely on a fast system clock. The serial clock, the select line and the serial input are treated as ordinary asynchronous inputs. Each passes through a two-stage synchronizer, and the serial clock edges are then found in the system clock domain. The serial output is modelled as a data bit plus an output enable. A pad driver outside the block turns a low enable into a high-impedance pin.

Top module: `serreg_port`

## Requirements
- R1: The command byte is the first 8 serial bits after select goes low. Serial bit 0 is the read/write flag, serial bits 1 to 5 are the register address with address bit 0 first, and serial bits 6 and 7 are reserved.
- R2: A flag value of 1 makes the transaction a read and leaves every register unchanged, whatever arrives on the serial input during the data byte. A flag value of 0 makes it a write.
- R3: The 5-bit address selects one of 32 independent registers, 0 to 31. A write changes only the addressed register.
- R4: Data bytes move with data bit 0 first and data bit 7 last, on input and on output.
- R5: With the serial clock idling low, the serial input is sampled on rising serial clock edges and the serial output changes only after falling serial clock edges.
- R6: The two reserved command bits have no effect on which register is reached or on the data moved.
- R7: If select goes high before the 16th rising serial clock edge, the transaction is dropped and no register is written.
- R8: The output enable is low whenever select is inactive and throughout the command byte. It goes high only in the data byte of a read, starting at the falling serial clock edge that follows the 8th rising edge.
- R9: A write stores the whole data byte in the addressed register once the 16th bit has been sampled. Serial clock edges after the 16th, up to the end of select, are ignored.
- R10: After reset all registers read as 0x00 and the output enable is low.
- R11: Transfers are correct when each serial clock phase lasts at least two system clock cycles, which means a serial clock of at most one quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| csn_i | input | 1 | Active-low select that frames one transaction |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_en_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The hardest case to reach is a select release that lands close to the commit point, such as after 15 bits or during extra clocking beyond bit 16. A correct port and a port that commits one bit early behave the same everywhere else. The bench therefore runs frames of exactly 12, 15, 16 and 20 bits, and after each one reads the target register back through a normal read. A behavioural reference model tracks the expected register contents. On every system clock, a monitor checks the output enable against the phase the host task is in.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int NREGS      = 1 << ADDR_W;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serreg_edge.sv
module serreg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic csn_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act
);
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_act    = ~csn_s;
endmodule

// File: rtl/serreg_engine.sv
module serreg_engine
  import serreg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_en_o,
  output logic          rd_flag_o,
  output logic [CW-1:0] bit_cnt_o
);
  localparam logic [CW-1:0] CMD_END   = CW'(DW);
  localparam logic [CW-1:0] CMD_LAST  = CW'(DW - 1);
  localparam logic [CW-1:0] FRAME_END = CW'(2 * DW);
  localparam logic [CW-1:0] DATA_LAST = CW'(2 * DW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] cmd_q, cmd_d;
  logic [DW-1:0] din_q, din_d;
  logic [DW-1:0] dout_q, dout_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          rd_q, rd_d;
  logic          ld_q, ld_d;
  logic          sdo_q, sdo_d;
  logic          en_q, en_d;
  logic          wr_q, wr_d;

  always_comb begin
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    din_d  = din_q;
    dout_d = dout_q;
    wdat_d = wdat_q;
    addr_d = addr_q;
    rd_d   = rd_q;
    sdo_d  = sdo_q;
    en_d   = en_q;
    ld_d   = 1'b0;
    wr_d   = 1'b0;
    if (!cs_act) begin
      cnt_d = '0;
      en_d  = 1'b0;
    end else begin
      if (ld_q) dout_d = rd_data_i;
      if (sclk_rise && (cnt_q < FRAME_END)) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q < CMD_END) begin
          cmd_d = {sdi, cmd_q[DW-1:1]};
          if (cnt_q == CMD_LAST) begin
            rd_d   = cmd_d[0];
            addr_d = cmd_d[AW:1];
            ld_d   = cmd_d[0];
          end
        end else begin
          din_d = {sdi, din_q[DW-1:1]};
          if ((cnt_q == DATA_LAST) && !rd_q) begin
            wr_d   = 1'b1;
            wdat_d = din_d;
          end
        end
      end
      if (sclk_fall && rd_q && (cnt_q >= CMD_END) && (cnt_q < FRAME_END)) begin
        sdo_d  = dout_q[0];
        dout_d = {1'b0, dout_q[DW-1:1]};
        en_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      din_q  <= '0;
      dout_q <= '0;
      wdat_q <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      ld_q   <= 1'b0;
      sdo_q  <= 1'b0;
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      din_q  <= din_d;
      dout_q <= dout_d;
      wdat_q <= wdat_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      ld_q   <= ld_d;
      sdo_q  <= sdo_d;
      en_q   <= en_d;
      wr_q   <= wr_d;
    end
  end

  assign addr_o    = addr_q;
  assign wr_stb_o  = wr_q;
  assign wr_data_o = wdat_q;
  assign sdo_o     = sdo_q;
  assign sdo_en_o  = en_q;
  assign rd_flag_o = rd_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NR = NREGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_stb_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] regs_w [NR];

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic          sel;
    logic [DW-1:0] val_q;
    assign sel = wr_stb_i && (addr_i == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (sel) val_q <= wr_data_i;
    end
    assign regs_w[i] = val_q;
  end

  assign rd_data_o = regs_w[addr_i];
endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import serreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic              sclk_rise, sclk_fall, cs_act;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              rd_flag;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  serreg_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({sdi_i, csn_i, sclk_i}),
    .q_o   (pins_s)
  );

  serreg_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sclk_s    (pins_s[0]),
    .csn_s     (pins_s[1]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act)
  );

  serreg_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi       (pins_s[2]),
    .rd_data_i (rd_data),
    .addr_o    (reg_addr),
    .wr_stb_o  (wr_stb),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o),
    .rd_flag_o (rd_flag),
    .bit_cnt_o (bit_cnt)
  );

  serreg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_i    (reg_addr),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/serreg_chk.sv
module serreg_chk
  import serreg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             csn_i,
  input logic             sdo_o,
  input logic             sdo_en_o,
  input logic             sclk_fall,
  input logic             rd_flag,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             wr_stb
);
  localparam logic [CNT_W-1:0] CMD_END   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !sdo_en_o); // R8

  AST_EN_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en_o |-> (rd_flag && (bit_cnt >= CMD_END))); // R8

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_fall)); // R5

  AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ((bit_cnt == FRAME_END) && !rd_flag)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FRAME_END); // R9
endmodule

bind serreg_port serreg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .csn_i     (csn_i),
  .sdo_o     (sdo_o),
  .sdo_en_o  (sdo_en_o),
  .sclk_fall (sclk_fall),
  .rd_flag   (rd_flag),
  .bit_cnt   (bit_cnt),
  .wr_stb    (wr_stb)
);

// File: tb/serreg_port_test.sv
module serreg_port_test;
  logic clk, rst_n, sclk, csn, sdi, sdo, sdo_en;
  int   n_checks, n_fail;
  int   quiet_bad, en_bad;
  logic quiet, cur_rd;
  logic [7:0] ref_regs [32];
  logic [7:0] rv;

  serreg_port uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk),
    .csn_i    (csn),
    .sdi_i    (sdi),
    .sdo_o    (sdo),
    .sdo_en_o (sdo_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // per-clock comparison: enable must stay low outside a read data byte (R8)
  always @(negedge clk) begin
    if (rst_n && (quiet || !cur_rd) && sdo_en) quiet_bad++;
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // one serial frame; each phase lasts 4 system clocks (R11 margin)
  task automatic xfer(input logic rd, input logic [4:0] a, input logic [1:0] rsv,
                      input logic [7:0] wd, input int nbits, output logic [7:0] rdv);
    rdv = '0;
    cur_rd = rd;
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (i == 0)      b = rd;
      else if (i < 6)  b = a[i-1];
      else if (i < 8)  b = rsv[i-6];
      else if (i < 16) b = wd[i-8];
      else             b = 1'b1;
      sdi = b;
      repeat (4) @(negedge clk);
      if (rd && i >= 8 && i < 16) begin
        rdv[i-8] = sdo;
        if (!sdo_en) en_bad++;
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (i == 7) quiet = 1'b0;
    end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    quiet = 1'b1;
    if (!rd && nbits >= 16) ref_regs[a] = wd;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [1:0] rsv);
    logic [7:0] v;
    xfer(1'b1, a, rsv, 8'h00, 16, v);
    chk(tag, v, ref_regs[a]);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; quiet_bad = 0; en_bad = 0;
    quiet = 1'b1; cur_rd = 1'b0;
    sclk = 1'b0; csn = 1'b1; sdi = 1'b0; rst_n = 1'b0;
    for (int k = 0; k < 32; k++) ref_regs[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R10 enable low after reset", {7'b0, sdo_en}, 8'h00);
    rd_chk("R10 reg0 reset", 5'd0, 2'b00);
    rd_chk("R10 reg31 reset", 5'd31, 2'b00);

    xfer(1'b0, 5'd3, 2'b00, 8'hA5, 16, rv);
    rd_chk("R2 write then read reg3", 5'd3, 2'b00);

    xfer(1'b0, 5'd0, 2'b00, 8'h01, 16, rv);
    xfer(1'b0, 5'd31, 2'b00, 8'h80, 16, rv);
    rd_chk("R4 bit0-only byte at reg0", 5'd0, 2'b00);
    rd_chk("R4 bit7-only byte at reg31", 5'd31, 2'b00);
    rd_chk("R3 reg3 kept after other writes", 5'd3, 2'b00);

    xfer(1'b0, 5'h11, 2'b00, 8'h77, 16, rv);
    rd_chk("R1 address 0x11", 5'h11, 2'b00);
    rd_chk("R1 address 0x10 untouched", 5'h10, 2'b00);
    rd_chk("R1 address 0x01 untouched", 5'h01, 2'b00);

    xfer(1'b0, 5'd10, 2'b11, 8'h3C, 16, rv);
    rd_chk("R6 reserved bits set on write and read", 5'd10, 2'b11);
    rd_chk("R6 reserved bits clear on read", 5'd10, 2'b00);

    xfer(1'b0, 5'd3, 2'b00, 8'hFF, 12, rv);
    rd_chk("R7 abort after 12 bits", 5'd3, 2'b00);
    xfer(1'b0, 5'd3, 2'b00, 8'h00, 15, rv);
    rd_chk("R7 abort after 15 bits", 5'd3, 2'b00);

    xfer(1'b0, 5'd7, 2'b00, 8'h5A, 20, rv);
    rd_chk("R9 extra clocks after 16th bit ignored", 5'd7, 2'b00);

    xfer(1'b1, 5'd7, 2'b00, 8'hC3, 16, rv);
    chk("R2 read returns stored byte", rv, 8'h5A);
    rd_chk("R2 read with host data leaves reg intact", 5'd7, 2'b00);

    chk("R8 enable outside read data phase", quiet_bad[7:0], 8'h00);
    chk("R5 enable driven at each sampled read bit", en_bad[7:0], 8'h00);
    chk("R11 failures at 4-cycle phases", n_fail[7:0], 8'h00);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule